// File: doc/BRIEF.md
# Paged DMA Transfer Sequencer

This block moves one block of data between a 16-bit device buffer and a 32-bit memory bus. It holds a virtual address register and a byte count register. The count register counts up towards its overflow point, so the bytes it still allows are two to the power of the count width minus its value. A start strobe names a direction and a requested length. The sequencer then works through the block one page at a time. For each page it asks an external page-map port to translate the address, and it checks that the translated address falls inside memory. It picks the widest access that the chunk's alignment permits and runs the memory cycles one at a time.

When the transfer stops, both registers advance by the number of bytes actually moved. A one-cycle done pulse reports that number. A map miss or a non-memory address ends the transfer early and raises a sticky status flag. A new start clears both flags. The two registers are loaded through a small configuration port while the block is idle.

Top module: `dma_page_seq`

## Requirements
- R1: After reset, busy, done, mem_valid, buf_we, both status flags, va_o and bc_o are all 0.
- R2: The transfer length is the smaller of req_len and (2^BC_W minus the count register). The count register value 0 therefore allows 2^BC_W bytes.
- R3: No chunk crosses a 512-byte page. A chunk's length is the bytes left in the page from the translated address, clipped to the bytes still to move, and each chunk performs one map lookup.
- R4: If map_ok is 0 for a chunk's lookup, the transfer stops there and st_mapfail is set. Bytes moved before that point still count.
- R5: If a translated address is at or above MEM_BYTES, the transfer stops before any access in that chunk and st_timeout is set.
- R6: If the chunk address or the chunk length is odd, the chunk moves bytes. Each cycle has mem_be equal to 1 shifted left by mem_addr[1:0].
- R7: Otherwise, if either value is not a multiple of 4, the chunk moves 16-bit words. mem_be is 4'b0011 when mem_addr[1] is 0 and 4'b1100 when it is 1.
- R8: Only when both values are multiples of 4 does the chunk move longwords, with mem_be equal to 4'b1111 and mem_addr[1:0] equal to 0.
- R9: In byte mode, running byte index k maps to buffer word k/2. An even k uses the low byte (buf_be 2'b01) and an odd k uses the high byte (buf_be 2'b10).
- R10: One longword maps to two buffer words: bits 15:0 go to the lower buffer index and bits 31:16 to the next. A read writes the lower index first.
- R11: At the end of a transfer, va_o and bc_o advance by the moved byte count, each masked to its own width. done pulses for exactly one cycle with done_bytes equal to that count.
- R12: At most one memory cycle is outstanding. Once mem_valid is raised, mem_valid, mem_addr, mem_be and mem_wdata hold until a cycle with mem_ready set.
- R13: cfg_we has no effect on va_o or bc_o while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Load address and count registers (idle only) |
| cfg_va | input | VA_W | Address register load value |
| cfg_bc | input | BC_W | Count register load value |
| start | input | 1 | Begin a transfer |
| dir_rd | input | 1 | 1: memory to buffer, 0: buffer to memory |
| req_len | input | BC_W+1 | Bytes requested by the device |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_bytes | output | BC_W+1 | Bytes moved by the last transfer |
| va_o | output | VA_W | Address register |
| bc_o | output | BC_W | Count register |
| st_mapfail | output | 1 | Sticky: stopped on a map miss |
| st_timeout | output | 1 | Sticky: stopped on a non-memory address |
| map_req | output | 1 | Lookup requested this cycle |
| map_va | output | VA_W | Virtual address to translate |
| map_ok | input | 1 | Translation valid (same cycle) |
| map_pa | input | PA_W | Translated byte address (same cycle) |
| mem_valid | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 for a memory write |
| mem_addr | output | PA_W | Byte address of the cycle |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data, lane-replicated |
| mem_ready | input | 1 | Memory accepts or completes the cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| buf_idx | output | BC_W | Buffer word index |
| buf_rdata | input | 16 | Buffer word at buf_idx (same cycle) |
| buf_we | output | 1 | Buffer write strobe |
| buf_be | output | 2 | Buffer byte enables |
| buf_wdata | output | 16 | Buffer write data |

## Verification
Done, done_bytes and the updated va_o and bc_o all appear in the cycle right after the sequencer's closing state. The bench therefore polls done on the falling edge and reads every result at that same edge. It then checks, one falling edge later, that done has dropped. The bench's memory model raises mem_ready one cycle after it sees mem_valid. It applies writes and counts the access widths on that same falling edge, so the width counts are complete by the time done appears. Buffer writes land at least two cycles before done, so buffer and memory contents are compared only after done has been observed.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {W_BYTE, W_WORD, W_LONG} width_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHUNK, S_GATH, S_MEM, S_PUT, S_FIN
  } state_e;

  // Access width from the low bits of address and length.
  function automatic width_e f_width(input logic [1:0] a_lo, input logic [1:0] n_lo);
    if (a_lo[0] | n_lo[0])      return W_BYTE;
    else if (a_lo[1] | n_lo[1]) return W_WORD;
    else                        return W_LONG;
  endfunction

  // Bytes moved per memory cycle.
  function automatic logic [2:0] f_step(input width_e w);
    case (w)
      W_BYTE:  return 3'd1;
      W_WORD:  return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_len_calc.sv
module dma_len_calc #(
  parameter int BC_W = 16
) (
  input  logic [BC_W-1:0] bc,
  input  logic [BC_W:0]   req,
  output logic [BC_W:0]   xlen
);
  localparam int CW = BC_W + 1;

  logic [CW-1:0] room;

  // counter counts up to its overflow point
  assign room = {1'b1, {BC_W{1'b0}}} - {1'b0, bc};
  assign xlen = (req < room) ? req : room;

endmodule

// File: rtl/dma_chunk_plan.sv
module dma_chunk_plan
  import dma_pkg::*;
#(
  parameter int BC_W   = 16,
  parameter int PA_W   = 24,
  parameter int PAGE_W = 9
) (
  input  logic [PA_W-1:0] pa,
  input  logic [BC_W:0]   left,
  output logic [BC_W:0]   clen,
  output width_e          wid
);
  localparam int CW         = BC_W + 1;
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [CW-1:0] in_page;

  assign in_page = CW'(PAGE_BYTES) - CW'(pa[PAGE_W-1:0]);
  assign clen    = (in_page > left) ? left : in_page;
  assign wid     = f_width(pa[1:0], clen[1:0]);

endmodule

// File: rtl/dma_lane_steer.sv
module dma_lane_steer
  import dma_pkg::*;
(
  input  width_e      wid,
  input  logic [1:0]  a_lo,
  input  logic        bidx0,
  input  logic        half,
  input  logic [15:0] wlo,
  input  logic [15:0] whi,
  input  logic [31:0] rbuf,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  output logic [1:0]  buf_be,
  output logic [15:0] buf_wdata
);
  logic [7:0]  wbyte;
  logic [7:0]  rbyte;
  logic [31:0] rshift;

  assign wbyte  = bidx0 ? wlo[15:8] : wlo[7:0];
  assign rshift = rbuf >> {a_lo, 3'b000};
  assign rbyte  = rshift[7:0];

  always_comb begin
    case (wid)
      W_BYTE: begin
        mem_be    = 4'b0001 << a_lo;
        mem_wdata = {4{wbyte}};
        buf_be    = bidx0 ? 2'b10 : 2'b01;
        buf_wdata = {2{rbyte}};
      end
      W_WORD: begin
        mem_be    = a_lo[1] ? 4'b1100 : 4'b0011;
        mem_wdata = {2{wlo}};
        buf_be    = 2'b11;
        buf_wdata = a_lo[1] ? rbuf[31:16] : rbuf[15:0];
      end
      default: begin
        mem_be    = 4'b1111;
        mem_wdata = {whi, wlo};
        buf_be    = 2'b11;
        buf_wdata = half ? rbuf[31:16] : rbuf[15:0];
      end
    endcase
  end

endmodule

// File: rtl/dma_page_seq.sv
module dma_page_seq
  import dma_pkg::*;
#(
  parameter int BC_W      = 16,
  parameter int VA_W      = 18,
  parameter int PA_W      = 24,
  parameter int PAGE_W    = 9,
  parameter int MEM_BYTES = 1 << 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [VA_W-1:0]   cfg_va,
  input  logic [BC_W-1:0]   cfg_bc,
  input  logic              start,
  input  logic              dir_rd,
  input  logic [BC_W:0]     req_len,
  output logic              busy,
  output logic              done,
  output logic [BC_W:0]     done_bytes,
  output logic [VA_W-1:0]   va_o,
  output logic [BC_W-1:0]   bc_o,
  output logic              st_mapfail,
  output logic              st_timeout,
  output logic              map_req,
  output logic [VA_W-1:0]   map_va,
  input  logic              map_ok,
  input  logic [PA_W-1:0]   map_pa,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  output logic [BC_W-1:0]   buf_idx,
  input  logic [15:0]       buf_rdata,
  output logic              buf_we,
  output logic [1:0]        buf_be,
  output logic [15:0]       buf_wdata
);
  localparam int CW         = BC_W + 1;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam logic [PA_W-1:0] MEM_TOP = PA_W'(MEM_BYTES);

  state_e          state_q;
  logic            dir_q;
  logic [CW-1:0]   xlen_q, moved_q, cleft_q, dbytes_q;
  logic [PA_W-1:0] cpa_q;
  width_e          cwid_q;
  logic            half_q;
  logic [15:0]     wlo_q, whi_q;
  logic [31:0]     rbuf_q;
  logic [VA_W-1:0] va_q;
  logic [BC_W-1:0] bc_q;
  logic            done_q, mapfail_q, tmo_q;

  // combinational helpers
  logic [CW-1:0]   xlen_w, clen_w, step_w, left_w;
  width_e          cwid_w;

  // named internal events
  logic ev_start, ev_beat, ev_adv, ev_last, ev_fin, ev_all, ev_miss, ev_nxm;

  dma_len_calc #(.BC_W(BC_W)) u_len (
    .bc   (bc_q),
    .req  (req_len),
    .xlen (xlen_w)
  );

  assign left_w = xlen_q - moved_q;

  dma_chunk_plan #(.BC_W(BC_W), .PA_W(PA_W), .PAGE_W(PAGE_W)) u_plan (
    .pa   (map_pa),
    .left (left_w),
    .clen (clen_w),
    .wid  (cwid_w)
  );

  dma_lane_steer u_lane (
    .wid       (cwid_q),
    .a_lo      (cpa_q[1:0]),
    .bidx0     (moved_q[0]),
    .half      (half_q),
    .wlo       (wlo_q),
    .whi       (whi_q),
    .rbuf      (rbuf_q),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .buf_be    (buf_be),
    .buf_wdata (buf_wdata)
  );

  assign step_w = CW'(f_step(cwid_q));

  assign ev_start = (state_q == S_IDLE) && start;
  assign ev_all   = (state_q == S_CHUNK) && (moved_q == xlen_q);
  assign ev_miss  = (state_q == S_CHUNK) && !ev_all && !map_ok;
  assign ev_nxm   = (state_q == S_CHUNK) && !ev_all && map_ok && (map_pa >= MEM_TOP);
  assign ev_beat  = mem_valid && mem_ready;
  assign ev_adv   = (ev_beat && !dir_q) ||
                    ((state_q == S_PUT) && !((cwid_q == W_LONG) && !half_q));
  assign ev_last  = ev_adv && (cleft_q == step_w);
  assign ev_fin   = (state_q == S_FIN);

  assign busy       = (state_q != S_IDLE);
  assign done       = done_q;
  assign done_bytes = dbytes_q;
  assign va_o       = va_q;
  assign bc_o       = bc_q;
  assign st_mapfail = mapfail_q;
  assign st_timeout = tmo_q;
  assign map_req    = (state_q == S_CHUNK) && !ev_all;
  assign map_va     = va_q + VA_W'(moved_q);
  assign mem_valid  = (state_q == S_MEM);
  assign mem_we     = !dir_q;
  assign mem_addr   = cpa_q;
  assign buf_we     = (state_q == S_PUT);
  assign buf_idx    = moved_q[BC_W:1] + BC_W'(half_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      dir_q     <= 1'b0;
      xlen_q    <= '0;
      moved_q   <= '0;
      cleft_q   <= '0;
      dbytes_q  <= '0;
      cpa_q     <= '0;
      cwid_q    <= W_BYTE;
      half_q    <= 1'b0;
      wlo_q     <= '0;
      whi_q     <= '0;
      rbuf_q    <= '0;
      va_q      <= '0;
      bc_q      <= '0;
      done_q    <= 1'b0;
      mapfail_q <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (cfg_we) begin
            va_q <= cfg_va;
            bc_q <= cfg_bc;
          end
          if (start) begin
            dir_q     <= dir_rd;
            xlen_q    <= xlen_w;
            moved_q   <= '0;
            mapfail_q <= 1'b0;
            tmo_q     <= 1'b0;
            state_q   <= S_CHUNK;
          end
        end
        S_CHUNK: begin
          if (ev_all) begin
            state_q <= S_FIN;
          end else if (ev_miss) begin
            mapfail_q <= 1'b1;
            state_q   <= S_FIN;
          end else if (ev_nxm) begin
            tmo_q   <= 1'b1;
            state_q <= S_FIN;
          end else begin
            cpa_q   <= map_pa;
            cleft_q <= clen_w;
            cwid_q  <= cwid_w;
            half_q  <= 1'b0;
            state_q <= dir_q ? S_MEM : S_GATH;
          end
        end
        S_GATH: begin
          if (!half_q) begin
            wlo_q <= buf_rdata;
            if (cwid_q == W_LONG) half_q <= 1'b1;
            else                  state_q <= S_MEM;
          end else begin
            whi_q   <= buf_rdata;
            half_q  <= 1'b0;
            state_q <= S_MEM;
          end
        end
        S_MEM: begin
          if (mem_ready && dir_q) begin
            rbuf_q  <= mem_rdata;
            half_q  <= 1'b0;
            state_q <= S_PUT;
          end
        end
        S_PUT: begin
          if ((cwid_q == W_LONG) && !half_q) half_q <= 1'b1;
        end
        S_FIN: begin
          va_q     <= va_q + VA_W'(moved_q);
          bc_q     <= bc_q + BC_W'(moved_q);
          dbytes_q <= moved_q;
          done_q   <= 1'b1;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase

      if (ev_adv) begin
        moved_q <= moved_q + step_w;
        cpa_q   <= cpa_q + PA_W'(step_w);
        cleft_q <= cleft_q - step_w;
        half_q  <= 1'b0;
        if (ev_last)    state_q <= S_CHUNK;
        else if (dir_q) state_q <= S_MEM;
        else            state_q <= S_GATH;
      end
    end
  end

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata));

  // R3
  page_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (CW'(cpa_q[PAGE_W-1:0]) + cleft_q) <= CW'(PAGE_BYTES));

  // R6
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

  // R8
  long_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && (mem_be == 4'hF) |-> (mem_addr[1:0] == 2'b00));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13
  cfg_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_we && !ev_fin |=> $stable(va_o) && $stable(bc_o));

  // R2
  moved_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    moved_q <= xlen_q);

endmodule

// File: tb/dma_page_seq_test.sv
`timescale 1ns/1ps
module dma_page_seq_test;
  localparam int BC_W = 16, VA_W = 18, PA_W = 24;
  localparam int BAD_VPN = 30, NXM_VPN = 40;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, start = 0, dir_rd = 0;
  logic [VA_W-1:0] cfg_va = '0;
  logic [BC_W-1:0] cfg_bc = '0;
  logic [BC_W:0]   req_len = '0;
  logic busy, done, st_mapfail, st_timeout, map_req, map_ok;
  logic [BC_W:0]   done_bytes;
  logic [VA_W-1:0] va_o, map_va;
  logic [BC_W-1:0] bc_o, buf_idx;
  logic [PA_W-1:0] map_pa, mem_addr;
  logic mem_valid, mem_we, mem_ready = 0, buf_we;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [15:0] buf_rdata, buf_wdata;
  logic [1:0]  buf_be;

  int checks = 0, errors = 0;
  int nb = 0, nw = 0, nl = 0;
  logic [15:0] bufw [0:255];
  logic [7:0]  mem [int];

  always #10 clk = ~clk;

  dma_page_seq uut (.*);

  function automatic int frame_of(int vpn);
    if (vpn == NXM_VPN) return 32'h900;
    return (vpn * 5 + 11) & 2047;
  endfunction
  function automatic int xpa(int va);
    return frame_of((va >> 9) & 511) * 512 + (va & 511);
  endfunction
  function automatic logic [7:0] rdm(int a);
    if (mem.exists(a)) return mem[a];
    return 8'((a * 7) + (a >> 8));
  endfunction
  function automatic logic [7:0] bufbyte(int k);
    return k[0] ? bufw[k >> 1][15:8] : bufw[k >> 1][7:0];
  endfunction

  assign map_ok    = ((map_va >> 9) != BAD_VPN);
  assign map_pa    = PA_W'(xpa(int'(map_va)));
  assign buf_rdata = bufw[buf_idx[7:0]];

  // memory model: one wait cycle per access
  always @(negedge clk) begin
    if (mem_ready) mem_ready = 1'b0;
    else if (mem_valid) begin
      int a;
      a = int'({mem_addr[PA_W-1:2], 2'b00});
      for (int l = 0; l < 4; l++) begin
        mem_rdata[8*l +: 8] = rdm(a + l);
        if (mem_we && mem_be[l]) mem[a + l] = mem_wdata[8*l +: 8];
      end
      case ($countones(mem_be))
        1: nb++;
        2: nw++;
        default: nl++;
      endcase
      mem_ready = 1'b1;
    end
    if (buf_we) begin
      if (buf_be[0]) bufw[buf_idx[7:0]][7:0]  = buf_wdata[7:0];
      if (buf_be[1]) bufw[buf_idx[7:0]][15:8] = buf_wdata[15:8];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int got, gva, gbc;
  bit gmf, gto;

  task automatic run(input bit d, input int va, input int bc, input int req, input bit inject);
    int n;
    @(negedge clk);
    cfg_we = 1; cfg_va = VA_W'(va); cfg_bc = BC_W'(bc);
    @(negedge clk);
    cfg_we = 0; start = 1; dir_rd = d; req_len = (BC_W+1)'(req);
    nb = 0; nw = 0; nl = 0;
    @(negedge clk);
    start = 0;
    n = 0;
    while (!done && n < 4000) begin
      if (inject && n == 4) begin cfg_we = 1; cfg_va = 18'h1234; cfg_bc = 16'h5555; end
      if (inject && n == 5) cfg_we = 0;
      @(negedge clk);
      n++;
    end
    cfg_we = 0;
    chk(n < 4000, "R11 done seen", n, 0);
    got = int'(done_bytes); gva = int'(va_o); gbc = int'(bc_o);
    gmf = st_mapfail; gto = st_timeout;
    @(negedge clk);
    chk(!done, "R11 done one cycle", done, 0);
  endtask

  task automatic chk_rd(input int va, input int n, input string tag);
    int bad = -1;
    for (int k = 0; k < n; k++)
      if (bad < 0 && bufbyte(k) !== rdm(xpa(va + k))) bad = k;
    chk(bad < 0, tag, (bad < 0) ? 0 : bufbyte(bad), (bad < 0) ? 0 : rdm(xpa(va + bad)));
  endtask

  task automatic chk_wr(input int va, input int n, input string tag);
    int bad = -1;
    for (int k = 0; k < n; k++)
      if (bad < 0 && rdm(xpa(va + k)) !== bufbyte(k)) bad = k;
    chk(bad < 0, tag, (bad < 0) ? 0 : rdm(xpa(va + bad)), (bad < 0) ? 0 : bufbyte(bad));
  endtask

  task automatic clr_buf();
    for (int i = 0; i < 256; i++) bufw[i] = 16'h0000;
  endtask

  task automatic t_reset();
    chk(!busy && !done && !mem_valid && !buf_we && !st_mapfail && !st_timeout,
        "R1 idle outputs", {busy, done, mem_valid, buf_we, st_mapfail, st_timeout}, 0);
    chk(va_o == 0 && bc_o == 0, "R1 registers", int'(va_o), 0);
  endtask

  task automatic t_read_long();
    clr_buf();
    run(1, 32'h000, 0, 16, 0);
    chk(got == 16 && nl == 4 && nw == 0 && nb == 0, "R8 long count", nl, 4);
    chk_rd(32'h000, 16, "R10 long read order");
    chk(gva == 16 && gbc == 16, "R11 regs advance", gva, 16);
  endtask

  task automatic t_read_word();
    clr_buf();
    run(1, 32'h202, 0, 12, 0);
    chk(nw == 6 && nl == 0 && nb == 0, "R7 word count", nw, 6);
    chk_rd(32'h202, 12, "R7 word data");
  endtask

  task automatic t_read_byte();
    clr_buf();
    run(1, 32'h401, 0, 5, 0);
    chk(nb == 5 && got == 5, "R6 byte count", nb, 5);
    chk_rd(32'h401, 5, "R9 byte lanes");
    chk(bufw[2][15:8] == 8'h00, "R9 untouched high byte", bufw[2][15:8], 0);
  endtask

  task automatic t_page_split();
    clr_buf();
    run(1, 32'h1FC, 0, 7, 0);
    chk(nl == 1 && nb == 3, "R3 split widths", nl * 16 + nb, 16 + 3);
    chk_rd(32'h1FC, 7, "R3 split data");
    clr_buf();
    run(1, 32'h3F8, 0, 24, 0);
    chk(nl == 6 && got == 24, "R3 page cross", nl, 6);
    chk_rd(32'h3F8, 24, "R3 page cross data");
  endtask

  task automatic t_clip();
    clr_buf();
    run(1, 32'h800, 32'hFFF0, 40, 0);
    chk(got == 16, "R2 clipped length", got, 16);
    chk(gbc == 0 && gva == 32'h810, "R11 masked count", gbc, 0);
  endtask

  task automatic t_mapfail();
    run(1, BAD_VPN * 512 - 8, 0, 32, 0);
    chk(got == 8 && gmf && !gto, "R4 map miss", got, 8);
    chk(gva == BAD_VPN * 512, "R4 partial advance", gva, BAD_VPN * 512);
  endtask

  task automatic t_nxm();
    run(1, NXM_VPN * 512, 32'h10, 8, 0);
    chk(got == 0 && gto && !gmf && (nb + nw + nl) == 0, "R5 timeout", got, 0);
    chk(gva == NXM_VPN * 512 && gbc == 32'h10, "R5 regs unchanged", gva, NXM_VPN * 512);
  endtask

  task automatic t_write();
    for (int i = 0; i < 256; i++) bufw[i] = 16'h3C00 ^ 16'(i * 291);
    run(0, 32'h7FA, 0, 10, 0);
    chk(nw == 3 && nl == 1 && got == 10, "R7 write widths", nw * 16 + nl, 49);
    chk_wr(32'h7FA, 10, "R10 write assembly");
    run(0, 32'hA03, 0, 3, 0);
    chk(nb == 3, "R6 write bytes", nb, 3);
    chk_wr(32'hA03, 3, "R9 write byte lanes");
  endtask

  task automatic t_cfg_busy();
    clr_buf();
    run(1, 32'hC00, 0, 64, 1);
    chk(gva == 32'hC40 && gbc == 64, "R13 load ignored while busy", gva, 32'hC40);
  endtask

  task automatic t_zero();
    run(1, 32'hE00, 5, 0, 0);
    chk(got == 0 && (nb + nw + nl) == 0 && gva == 32'hE00 && gbc == 5, "R2 zero request", got, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clr_buf();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_long();
    t_read_word();
    t_read_byte();
    t_page_split();
    t_clip();
    t_mapfail();
    t_nxm();
    t_write();
    t_cfg_busy();
    t_zero();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule